// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block is the control and operand-steering core of a small 16-bit processor with three stages: fetch, decode with register read, and execute. One memory port serves both instruction fetches and data accesses. The block owns the program counter, the decode and execute pipeline registers and a one-entry side register for instructions. It drives the register-file read addresses and the write port, passes operands and an operation code to an external ALU, and returns the ALU result to the register file. The ALU and the register file sit outside. The register file is read asynchronously and written on the clock edge.

A load or store needs a second execute cycle, because its data access uses the shared port. In the first of these cycles the next instruction is fetched anyway and parked in the side register. In the second cycle the data access is made while the decode and execute registers are frozen. A dependent instruction receives the retiring result through forwarding, not the stale register value. A taken jump redirects the program counter and throws away the instructions behind it.

The memory port is a request/ready stream. The block raises `mem_req` with `mem_addr`, `mem_we` and `mem_wdata`. The transfer completes in a cycle where `mem_ready` is also high, and read data is taken from `mem_rdata` in that same cycle. While `mem_req` is high and `mem_ready` is low, the block keeps the request and all its attributes unchanged into the next cycle. Back-pressure from memory therefore freezes the whole pipeline.

Top module: `pipe3_hazard_ctrl`

## Requirements
- R1: Reset empties both pipeline registers and sets the program counter to RESET_PC (0). The first cycle after reset is a read request at that address, with no register or memory write.
- R2: Each accepted sequential fetch advances the fetch address by 2 bytes.
- R3: While a request is pending with `mem_ready` low, the request, its address and its write strobe stay the same next cycle, and no register write-back occurs.
- R4: Instruction word: opcode in bits 15:12, destination in 11:8, source A in 7:4, source B in 3:0. Opcode 8 loads and opcode 9 stores. In the first execute cycle of either, the next instruction is fetched into the side register while neither pipeline register loads.
- R5: In the second execute cycle of a load or store, the block requests the byte address held in operand A. A store also drives `mem_we` high and operand B on `mem_wdata`.
- R6: When the data access completes, a load writes `mem_rdata` to its destination register. In that same cycle the side register moves to decode and the decoded instruction moves to execute. The cycle after that fetches from the following address.
- R7: Opcodes 0 to 7 are ALU operations. `alu_op` carries the low three opcode bits, and the result goes to the destination register. A source register equal to the destination of the instruction retiring from execute takes that result on either operand.
- R8: A source register that matches a retiring load's destination takes the load data.
- R9: Opcode 12 is a conditional jump, taken when operand B is zero, with target equal to operand A. When taken, the block makes no memory request in that cycle, empties both pipeline registers, and fetches from the target next.
- R10: A jump with nonzero operand B falls through, and the instruction behind it executes.
- R11: An empty or discarded execute slot never writes a register and never writes memory.
- R12: If `mem_ready` is low during a fetch into the side register or during a data access, the freeze extends until it is high. The parked instruction stays intact and executes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Write strobe for the request |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Read data, valid when ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| rf_rd_addr_a | output | RAW | Register-file read address, operand A |
| rf_rd_addr_b | output | RAW | Register-file read address, operand B |
| rf_rd_data_a | input | DW | Register-file read data, operand A |
| rf_rd_data_b | input | DW | Register-file read data, operand B |
| rf_wr_en | output | 1 | Register write-back enable |
| rf_wr_addr | output | RAW | Write-back register index |
| rf_wr_data | output | DW | Write-back value |
| alu_op | output | 3 | ALU operation select |
| alu_a | output | DW | ALU operand A |
| alu_b | output | DW | ALU operand B |
| alu_result | input | DW | Combinational ALU result |
| dec_load_en | output | 1 | Decode pipeline register load enable |
| ex_load_en | output | 1 | Execute pipeline register load enable |

## Verification
The bound checker watches several rules on every cycle:
- a stalled request stays stable and suppresses write-back;
- the fetch address steps by two after each accepted fetch;
- both pipeline registers stay frozen in the first load/store cycle, which always leads into the access phase;
- the parked instruction is kept through a freeze;
- a taken jump issues no request and leaves both stages empty;
- an empty execute slot never writes.

Only the bench scenarios can show that forwarded operands carry the right value, that the parked instruction runs in program order after a stretched access, and that squashed wrong-path instructions leave the register file untouched. The bench does this by comparing final register contents and write-back values against expectations computed by hand.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

  typedef enum logic [2:0] {
    K_NOP   = 3'd0,
    K_ALU   = 3'd1,
    K_LOAD  = 3'd2,
    K_STORE = 3'd3,
    K_JUMP  = 3'd4
  } kind_e;

  localparam logic [3:0] OPC_LOAD  = 4'h8;
  localparam logic [3:0] OPC_STORE = 4'h9;
  localparam logic [3:0] OPC_JZ    = 4'hC;

  function automatic kind_e classify(input logic [3:0] opc);
    kind_e k;
    if (!opc[3]) k = K_ALU;
    else begin
      case (opc)
        OPC_LOAD:  k = K_LOAD;
        OPC_STORE: k = K_STORE;
        OPC_JZ:    k = K_JUMP;
        default:   k = K_NOP;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/pipe3_decode.sv
module pipe3_decode
  import pipe3_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic [DW-1:0]  instr,
  output kind_e          kind,
  output logic [RAW-1:0] rd_ix,
  output logic [RAW-1:0] ra_ix,
  output logic [RAW-1:0] rb_ix,
  output logic [2:0]     alu_code,
  output logic           writes_rf
);
  localparam int OPC_LO = DW - 4;

  logic [3:0] opc;

  assign opc       = instr[DW-1:OPC_LO];
  assign kind      = classify(opc);
  assign rd_ix     = instr[3*RAW-1:2*RAW];
  assign ra_ix     = instr[2*RAW-1:RAW];
  assign rb_ix     = instr[RAW-1:0];
  assign alu_code  = opc[2:0];
  assign writes_rf = (kind == K_ALU) || (kind == K_LOAD);

endmodule

// File: rtl/pipe3_fwd.sv
module pipe3_fwd #(
  parameter int DW  = 16,
  parameter int RAW = 4
) (
  input  logic [RAW-1:0] src_ix,
  input  logic [DW-1:0]  rf_val,
  input  logic           ret_wr,
  input  logic [RAW-1:0] ret_ix,
  input  logic [DW-1:0]  ret_val,
  output logic [DW-1:0]  opnd
);
  logic hit;

  assign hit  = ret_wr && (ret_ix == src_ix);
  assign opnd = hit ? ret_val : rf_val;

endmodule

// File: rtl/pipe3_seq.sv
module pipe3_seq
  import pipe3_pkg::*;
(
  input  logic  ex_live,
  input  kind_e ex_kind,
  input  logic  ex_b_zero,
  input  logic  acc_phase,
  input  logic  mem_ready,
  output logic  fetch_req,
  output logic  access_req,
  output logic  pc_inc,
  output logic  pc_jump,
  output logic  dec_en,
  output logic  dec_from_tmp,
  output logic  flush,
  output logic  tmp_en,
  output logic  phase_set,
  output logic  phase_clr,
  output logic  retire,
  output logic  ex_is_mem
);
  logic taken, first_cyc, second_cyc, plain_adv;

  always_comb begin
    ex_is_mem  = ex_live && ((ex_kind == K_LOAD) || (ex_kind == K_STORE));
    taken      = ex_live && (ex_kind == K_JUMP) && ex_b_zero;
    first_cyc  = ex_is_mem && !acc_phase;
    second_cyc = ex_is_mem && acc_phase;
    plain_adv  = !ex_is_mem && !taken && mem_ready;

    fetch_req    = !second_cyc && !taken;
    access_req   = second_cyc;
    pc_jump      = taken;
    pc_inc       = plain_adv || (first_cyc && mem_ready);
    tmp_en       = first_cyc && mem_ready;
    phase_set    = first_cyc && mem_ready;
    phase_clr    = second_cyc && mem_ready;
    retire       = plain_adv || (second_cyc && mem_ready);
    dec_en       = retire || taken;
    dec_from_tmp = second_cyc;
    flush        = taken;
  end

endmodule

// File: rtl/pipe3_hazard_ctrl.sv
module pipe3_hazard_ctrl
  import pipe3_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 16,
  parameter int          RAW      = 4,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic [RAW-1:0] rf_rd_addr_a,
  output logic [RAW-1:0] rf_rd_addr_b,
  input  logic [DW-1:0]  rf_rd_data_a,
  input  logic [DW-1:0]  rf_rd_data_b,
  output logic           rf_wr_en,
  output logic [RAW-1:0] rf_wr_addr,
  output logic [DW-1:0]  rf_wr_data,
  output logic [2:0]     alu_op,
  output logic [DW-1:0]  alu_a,
  output logic [DW-1:0]  alu_b,
  input  logic [DW-1:0]  alu_result,
  output logic           dec_load_en,
  output logic           ex_load_en
);
  localparam int NSRC        = 2;
  localparam int INSTR_BYTES = DW / 8;

  // architectural and pipeline state
  logic [AW-1:0]  pc_q;
  logic           dec_vld_q;
  logic [DW-1:0]  dec_ir_q;
  logic           tmp_vld_q;
  logic [DW-1:0]  tmp_ir_q;
  logic           ex_vld_q;
  kind_e          ex_kind_q;
  logic [RAW-1:0] ex_rd_q;
  logic [2:0]     ex_op_q;
  logic           ex_wr_q;
  logic [DW-1:0]  ex_a_q;
  logic [DW-1:0]  ex_b_q;
  logic           ph_q;

  // decode of the instruction in the decode register
  kind_e          d_kind;
  logic [RAW-1:0] d_rd, d_ra, d_rb;
  logic [2:0]     d_op;
  logic           d_wr;

  pipe3_decode #(.DW(DW), .RAW(RAW)) u_decode (
    .instr    (dec_ir_q),
    .kind     (d_kind),
    .rd_ix    (d_rd),
    .ra_ix    (d_ra),
    .rb_ix    (d_rb),
    .alu_code (d_op),
    .writes_rf(d_wr)
  );

  // sequencing
  logic fetch_req, access_req, pc_inc, pc_jump, dec_en, dec_from_tmp;
  logic flush, tmp_en, phase_set, phase_clr, retire, ex_is_mem, jmp_taken;

  pipe3_seq u_seq (
    .ex_live     (ex_vld_q),
    .ex_kind     (ex_kind_q),
    .ex_b_zero   (ex_b_q == '0),
    .acc_phase   (ph_q),
    .mem_ready   (mem_ready),
    .fetch_req   (fetch_req),
    .access_req  (access_req),
    .pc_inc      (pc_inc),
    .pc_jump     (pc_jump),
    .dec_en      (dec_en),
    .dec_from_tmp(dec_from_tmp),
    .flush       (flush),
    .tmp_en      (tmp_en),
    .phase_set   (phase_set),
    .phase_clr   (phase_clr),
    .retire      (retire),
    .ex_is_mem   (ex_is_mem)
  );

  assign jmp_taken = pc_jump;

  // result leaving execute and forwarding of it
  logic [DW-1:0]  ex_result;
  logic           ret_wr;
  logic [RAW-1:0] src_ix [NSRC];
  logic [DW-1:0]  src_rf [NSRC];
  logic [DW-1:0]  opnd   [NSRC];

  assign ex_result = (ex_kind_q == K_LOAD) ? mem_rdata : alu_result;
  assign ret_wr    = retire && ex_vld_q && ex_wr_q;
  assign src_ix[0] = d_ra;
  assign src_ix[1] = d_rb;
  assign src_rf[0] = rf_rd_data_a;
  assign src_rf[1] = rf_rd_data_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    pipe3_fwd #(.DW(DW), .RAW(RAW)) u_fwd (
      .src_ix (src_ix[g]),
      .rf_val (src_rf[g]),
      .ret_wr (ret_wr),
      .ret_ix (ex_rd_q),
      .ret_val(ex_result),
      .opnd   (opnd[g])
    );
  end

  // outputs
  assign mem_req      = fetch_req || access_req;
  assign mem_we       = access_req && (ex_kind_q == K_STORE);
  assign mem_addr     = access_req ? AW'(ex_a_q) : pc_q;
  assign mem_wdata    = ex_b_q;
  assign rf_rd_addr_a = d_ra;
  assign rf_rd_addr_b = d_rb;
  assign rf_wr_en     = ret_wr;
  assign rf_wr_addr   = ex_rd_q;
  assign rf_wr_data   = ex_result;
  assign alu_op       = ex_op_q;
  assign alu_a        = ex_a_q;
  assign alu_b        = ex_b_q;
  assign dec_load_en  = dec_en;
  assign ex_load_en   = dec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= AW'(RESET_PC);
      dec_vld_q <= 1'b0;
      dec_ir_q  <= '0;
      tmp_vld_q <= 1'b0;
      tmp_ir_q  <= '0;
      ex_vld_q  <= 1'b0;
      ex_kind_q <= K_NOP;
      ex_rd_q   <= '0;
      ex_op_q   <= '0;
      ex_wr_q   <= 1'b0;
      ex_a_q    <= '0;
      ex_b_q    <= '0;
      ph_q      <= 1'b0;
    end else begin
      if (pc_jump)     pc_q <= AW'(ex_a_q);
      else if (pc_inc) pc_q <= pc_q + AW'(INSTR_BYTES);

      if (tmp_en) begin
        tmp_ir_q  <= mem_rdata;
        tmp_vld_q <= 1'b1;
      end else if (dec_en && dec_from_tmp) begin
        tmp_vld_q <= 1'b0;
      end

      if (dec_en) begin
        if (flush) begin
          dec_vld_q <= 1'b0;
        end else if (dec_from_tmp) begin
          dec_vld_q <= tmp_vld_q;
          dec_ir_q  <= tmp_ir_q;
        end else begin
          dec_vld_q <= 1'b1;
          dec_ir_q  <= mem_rdata;
        end
        ex_vld_q  <= dec_vld_q && !flush;
        ex_kind_q <= d_kind;
        ex_rd_q   <= d_rd;
        ex_op_q   <= d_op;
        ex_wr_q   <= d_wr;
        ex_a_q    <= opnd[0];
        ex_b_q    <= opnd[1];
      end

      if (phase_set)      ph_q <= 1'b1;
      else if (phase_clr) ph_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pipe3_hazard_ctrl_chk.sv
module pipe3_hazard_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          rf_wr_en,
  input logic [AW-1:0] pc_q,
  input logic          fetch_req,
  input logic          ex_is_mem,
  input logic          ph_q,
  input logic          tmp_vld_q,
  input logic [DW-1:0] tmp_ir_q,
  input logic          jmp_taken,
  input logic          dec_vld_q,
  input logic          ex_vld_q,
  input logic          dec_load_en,
  input logic          ex_load_en
);
  localparam int STEP = DW / 8;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_no_wb_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |-> !rf_wr_en);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && mem_ready |=> pc_q == $past(pc_q) + AW'(STEP));

  assert_first_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_mem && !ph_q |-> !dec_load_en && !ex_load_en);

  assert_enter_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_mem && !ph_q && mem_ready |=> ph_q && tmp_vld_q && mem_req);

  assert_tmp_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_vld_q && !mem_ready |=> tmp_vld_q && $stable(tmp_ir_q));

  assert_jump_squash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_taken |=> !dec_vld_q && !ex_vld_q);

  assert_jump_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_taken |-> !mem_req);

  assert_bubble_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_vld_q |-> !rf_wr_en && !mem_we);

endmodule

bind pipe3_hazard_ctrl pipe3_hazard_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .rf_wr_en   (rf_wr_en),
  .pc_q       (pc_q),
  .fetch_req  (fetch_req),
  .ex_is_mem  (ex_is_mem),
  .ph_q       (ph_q),
  .tmp_vld_q  (tmp_vld_q),
  .tmp_ir_q   (tmp_ir_q),
  .jmp_taken  (jmp_taken),
  .dec_vld_q  (dec_vld_q),
  .ex_vld_q   (ex_vld_q),
  .dec_load_en(dec_load_en),
  .ex_load_en (ex_load_en)
);

// File: tb/pipe3_hazard_ctrl_bench.sv
`timescale 1ns/100ps
module pipe3_hazard_ctrl_bench;

  typedef struct packed {
    logic [15:0] i0, i1, i2, i3, i4, i5;
    logic [3:0]  reg_ix;
    logic [15:0] exp_val;
    logic [31:0] mask;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0123, 16'h0411, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd4,  16'h000A, 32'h0},         // R7 fwd A
    '{16'h0123, 16'h0521, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd5,  16'h0007, 32'h0},         // R7 fwd B
    '{16'h86A0, 16'h0766, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd7,  16'h2080, 32'h0},         // R8
    '{16'h90B3, 16'h89B0, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd9,  16'h0003, 32'h0},         // R5/R6
    '{16'hC0C0, 16'h0D22, 16'h0E33, 16'hF000, 16'h0F11, 16'hF000, 4'd13, 16'h000D, 32'h0},         // R9 squash
    '{16'hC0C0, 16'h0D22, 16'h0E33, 16'hF000, 16'h0F11, 16'hF000, 4'd15, 16'h0002, 32'h0},         // R9 target
    '{16'hC0C1, 16'h0D22, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd13, 16'h0004, 32'h0},         // R10
    '{16'h86A0, 16'h0766, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd7,  16'h2080, 32'h0000_0028}, // R12
    '{16'h90B3, 16'h89B0, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd9,  16'h0003, 32'h0000_0038}, // R12
    '{16'h0123, 16'h0411, 16'hF000, 16'hF000, 16'hF000, 16'hF000, 4'd4,  16'h000A, 32'h0000_0005}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_addr_a, rf_rd_addr_b, rf_wr_addr;
  logic [15:0] rf_rd_data_a, rf_rd_data_b, rf_wr_data;
  logic        rf_wr_en;
  logic [2:0]  alu_op;
  logic [15:0] alu_a, alu_b, alu_result;
  logic        dec_load_en, ex_load_en;

  logic [15:0] mem_m [128];
  logic [15:0] rf_m  [16];
  logic [7:0]  cyc;
  vec_t        cur;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pipe3_hazard_ctrl u_pipe3_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_rd_addr_a(rf_rd_addr_a), .rf_rd_addr_b(rf_rd_addr_b),
    .rf_rd_data_a(rf_rd_data_a), .rf_rd_data_b(rf_rd_data_b),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_result(alu_result),
    .dec_load_en(dec_load_en), .ex_load_en(ex_load_en)
  );

  // environment models: memory, register file, adder ALU
  assign mem_rdata    = mem_m[mem_addr[7:1]];
  assign rf_rd_data_a = rf_m[rf_rd_addr_a];
  assign rf_rd_data_b = rf_m[rf_rd_addr_b];
  assign alu_result   = alu_a + alu_b;
  assign mem_ready    = (cyc < 8'd32) ? ~cur.mask[cyc[4:0]] : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 8'd0;
      for (int w = 0; w < 128; w++) mem_m[w] <= 16'hF000;
      mem_m[0]  <= cur.i0;
      mem_m[1]  <= cur.i1;
      mem_m[2]  <= cur.i2;
      mem_m[3]  <= cur.i3;
      mem_m[4]  <= cur.i4;
      mem_m[5]  <= cur.i5;
      mem_m[64] <= 16'h1040;
      mem_m[65] <= 16'h1041;
      for (int k = 0; k < 16; k++) rf_m[k] <= 16'(k);
      rf_m[10] <= 16'h0080;
      rf_m[11] <= 16'h0082;
      rf_m[12] <= 16'h0008;
    end else begin
      if (cyc != 8'hFF) cyc <= cyc + 8'd1;
      if (rf_wr_en) rf_m[rf_wr_addr] <= rf_wr_data;
      if (mem_req && mem_ready && mem_we) mem_m[mem_addr[7:1]] <= mem_wdata;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(input vec_t v);
    cur = v;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic vec_t prog(input logic [15:0] a, input logic [15:0] b, input logic [31:0] m);
    vec_t v;
    v = '{a, b, 16'h0123, 16'hF000, 16'h0F11, 16'hF000, 4'd0, 16'h0, m};
    return v;
  endfunction

  initial begin
    // table walk
    for (int i = 0; i < NV; i++) begin
      start(VECS[i]);
      repeat (40) tick();
      chk($sformatf("table[%0d] R7 R8 R9 R10 R12 reg%0d", i, VECS[i].reg_ix),
          rf_m[VECS[i].reg_ix], VECS[i].exp_val);
    end

    // R1 reset state and R2 stepping
    start(prog(16'hF000, 16'hF000, 32'h0));
    chk("R1 req", 16'(mem_req), 16'h1);
    chk("R1 addr", mem_addr, 16'h0);
    chk("R1 we", 16'(mem_we), 16'h0);
    chk("R1 wb", 16'(rf_wr_en), 16'h0);
    tick(); chk("R2 addr c1", mem_addr, 16'h2);
    tick(); chk("R2 addr c2", mem_addr, 16'h4);

    // R3 fetch not-ready in cycle 1
    start(prog(16'hF000, 16'hF000, 32'h0000_0002));
    tick(); chk("R3 dec enable low", 16'(dec_load_en), 16'h0);
    tick(); chk("R3 repeat addr", mem_addr, 16'h2);
    tick(); chk("R3 resume addr", mem_addr, 16'h4);

    // R4 R5 R6 R8 load sequence
    start(prog(16'h86A0, 16'h0766, 32'h0));
    tick(); tick();
    chk("R4 fetch during first cycle", mem_addr, 16'h4);
    chk("R4 frozen", 16'(dec_load_en), 16'h0);
    tick();
    chk("R5 access addr", mem_addr, 16'h0080);
    chk("R5 read strobe", 16'(mem_we), 16'h0);
    chk("R6 load wb en", 16'(rf_wr_en), 16'h1);
    chk("R6 load wb data", rf_wr_data, 16'h1040);
    tick();
    chk("R6 next fetch", mem_addr, 16'h6);
    chk("R8 fwd load data", rf_wr_data, 16'h2080);
    chk("R8 wb reg", 16'(rf_wr_addr), 16'h7);

    // R5 store
    start(prog(16'h90B3, 16'hF000, 32'h0));
    tick(); tick(); tick();
    chk("R5 store addr", mem_addr, 16'h0082);
    chk("R5 store we", 16'(mem_we), 16'h1);
    chk("R5 store data", mem_wdata, 16'h0003);

    // R12 not-ready during access
    start(prog(16'h86A0, 16'h0766, 32'h0000_0008));
    tick(); tick(); tick();
    chk("R12 no wb while stalled", 16'(rf_wr_en), 16'h0);
    tick();
    chk("R12 access held", mem_addr, 16'h0080);
    chk("R12 wb after ready", 16'(rf_wr_en), 16'h1);
    tick();
    chk("R12 fetch resumes", mem_addr, 16'h6);
    chk("R12 dependent fwd", rf_wr_data, 16'h2080);
    tick();
    chk("R12 parked instr reg", 16'(rf_wr_addr), 16'h1);
    chk("R12 parked instr data", rf_wr_data, 16'h0005);

    // R12 not-ready during side-register fetch
    start(prog(16'h86A0, 16'h0766, 32'h0000_0004));
    tick(); tick(); tick();
    chk("R12 side fetch retried", mem_addr, 16'h4);
    tick();
    chk("R12 access after retry", mem_addr, 16'h0080);

    // R9 R11 taken jump
    start(prog(16'hC0C0, 16'h0D22, 32'h0));
    tick(); tick();
    chk("R9 no request", 16'(mem_req), 16'h0);
    tick();
    chk("R9 target fetch", mem_addr, 16'h8);
    chk("R11 bubble no wb c3", 16'(rf_wr_en), 16'h0);
    tick();
    chk("R11 bubble no wb c4", 16'(rf_wr_en), 16'h0);
    tick();
    chk("R9 target executes", 16'(rf_wr_addr), 16'hF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule